// File: doc/BRIEF.md
# Bridge Event Interrupt Aggregator

This block gathers the interrupt sources of a bus bridge into two groups and presents each group as one interrupt line. The first group holds bridge and link events such as error reports, address-translation faults, a received message, message-buffer overflow, link loss and bandwidth-management notices. Each of these arrives as a single-cycle pulse and is latched into a sticky status bit that software clears by writing a one. The second group mirrors the four shared legacy interrupt levels (A to D) of the downstream link. These bits follow their input wires and are never latched.

Each group has a mask register in which a one enables a source. A control register holds one global enable bit that gates both outputs. Software reaches the five registers through a simple word-addressed port. Writes take effect at the clock edge, and read data is returned combinationally from the word address. The event group has a fixed, sparse set of implemented positions. Every other position reads as zero and cannot be set.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset all five registers read zero and both interrupt outputs are low.
- R2: A pulse on `misc_evt_i` at an implemented position sets that status bit (word 0) at the next clock edge, and the bit stays set until it is cleared. The implemented positions are 0 (message received), 1 (message buffer overflow), 4 (slave error), 5 (master error), 6 (ingress translation error), 7 (egress translation error), 16 (fatal AER), 17 (non-fatal AER), 18 (correctable AER), 20 (unsupported request), 22 (non-fatal device error), 23 (fatal device error), 24 (link down), 25 (autonomous bandwidth change) and 26 (bandwidth management).
- R3: Positions of words 0 and 1 outside the implemented set always read 0. Events and writes at those positions have no effect.
- R4: Writing word 0 clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends set.
- R6: Word 2, bits 0 to 3, holds the levels of `intx_lvl_i` (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D), sampled at each clock edge. Its upper bits read 0, and writes to word 2 are ignored.
- R7: Word 1 is the event mask and word 3 is the legacy mask (bits 0 to 3). Both are written directly and read back, and a mask bit of 1 enables its source.
- R8: Word 4, bit 0, is the global enable. While it is 0 both outputs are low. The other bits of word 4 read 0.
- R9: `misc_irq_o` is high exactly when the global enable is set and some bit is set in both word 0 and word 1. It reflects the register state in the same cycle.
- R10: `intx_irq_o` is high exactly when the global enable is set and some bit is set in both word 2 and word 3.
- R11: Words 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| misc_evt_i | input | 32 | Bridge/link event pulses, one bit per position |
| intx_lvl_i | input | 4 | Legacy interrupt levels A..D |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| misc_irq_o | output | 1 | Event group interrupt |
| intx_irq_o | output | 1 | Legacy group interrupt |

## Verification
Event pulses, level inputs and register writes each land in a register at the first clock edge after they are driven. The read data and both interrupt outputs are combinational from those registers, so every result is due one edge after its stimulus. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the following edge, which keeps sampling clear of the edge itself. The bench sweeps all 32 event positions, all 256 legacy level/mask pairs and both enable states, computing each expected value arithmetically from the requirements.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int REG_DW = 32;
    localparam int REG_AW = 3;

    // Implemented event positions: 0,1,4,5,6,7,16,17,18,20,22,23,24,25,26
    localparam logic [REG_DW-1:0] MISC_IMPL_DEFAULT = 32'h07D7_00F3;

    typedef enum logic [REG_AW-1:0] {
        SEL_MISC_STAT = 3'd0,
        SEL_MISC_EN   = 3'd1,
        SEL_INTX_STAT = 3'd2,
        SEL_INTX_EN   = 3'd3,
        SEL_CTRL      = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/misc_evt_bank.sv
module misc_evt_bank #(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] clr_i,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] mask_wdata_i,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              pend_o
);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] mask;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over clear
        st_d.stat = ((st_q.stat & ~clr_i) | evt_i) & IMPL;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i & IMPL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign pend_o = |(st_q.stat & st_q.mask);

    // R2: an implemented event is latched at the next edge
    assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

    // R2/R4: set bits stay set unless a clearing write names them
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));

    // R4: cleared bits drop when no event arrives at them
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(clr_i & ~evt_i)) == '0));

    // R3: unimplemented bits never become set
    assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o | mask_o) & ~IMPL) == '0);

endmodule

// File: rtl/intx_level_bank.sv
module intx_level_bank #(
    parameter int NUM_INTX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INTX-1:0] lvl_i,
    input  logic                mask_we_i,
    input  logic [NUM_INTX-1:0] mask_wdata_i,
    output logic [NUM_INTX-1:0] lvl_o,
    output logic [NUM_INTX-1:0] mask_o,
    output logic                pend_o
);

    typedef struct packed {
        logic [NUM_INTX-1:0] lvl;
        logic [NUM_INTX-1:0] mask;
    } intx_state_t;

    intx_state_t         st_d, st_q;
    logic [NUM_INTX-1:0] line_act;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_INTX; g++) begin : g_line
        assign line_act[g] = st_q.lvl[g] & st_q.mask[g];
    end

    assign lvl_o  = st_q.lvl;
    assign mask_o = st_q.mask;
    assign pend_o = |line_act;

    // R6: status follows input levels with one register of delay
    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_o == $past(lvl_i)));

    // R7: mask holds when not written
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o));

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evt_irq_pkg::*;
#(
    parameter int                DATA_W    = REG_DW,
    parameter int                ADDR_W    = REG_AW,
    parameter int                NUM_INTX  = 4,
    parameter logic [DATA_W-1:0] MISC_IMPL = MISC_IMPL_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   misc_evt_i,
    input  logic [NUM_INTX-1:0] intx_lvl_i,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                misc_irq_o,
    output logic                intx_irq_o
);

    localparam int PAD_W = DATA_W - NUM_INTX;

    typedef struct packed {
        logic en;
    } ctrl_state_t;

    ctrl_state_t         ctl_d, ctl_q;

    logic                wr_misc_stat, wr_misc_en, wr_intx_en, wr_ctrl;
    logic [DATA_W-1:0]   misc_clr;
    logic [DATA_W-1:0]   misc_stat, misc_mask;
    logic [NUM_INTX-1:0] intx_lvl, intx_mask;
    logic                misc_pend, intx_pend;

    // write decode
    always_comb begin
        wr_misc_stat = reg_wr_i && (reg_addr_i == ADDR_W'(SEL_MISC_STAT));
        wr_misc_en   = reg_wr_i && (reg_addr_i == ADDR_W'(SEL_MISC_EN));
        wr_intx_en   = reg_wr_i && (reg_addr_i == ADDR_W'(SEL_INTX_EN));
        wr_ctrl      = reg_wr_i && (reg_addr_i == ADDR_W'(SEL_CTRL));
        misc_clr     = wr_misc_stat ? reg_wdata_i : '0;
    end

    misc_evt_bank #(
        .DATA_W (DATA_W),
        .IMPL   (MISC_IMPL)
    ) u_misc (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (misc_evt_i),
        .clr_i        (misc_clr),
        .mask_we_i    (wr_misc_en),
        .mask_wdata_i (reg_wdata_i),
        .stat_o       (misc_stat),
        .mask_o       (misc_mask),
        .pend_o       (misc_pend)
    );

    intx_level_bank #(
        .NUM_INTX (NUM_INTX)
    ) u_intx (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_i        (intx_lvl_i),
        .mask_we_i    (wr_intx_en),
        .mask_wdata_i (reg_wdata_i[NUM_INTX-1:0]),
        .lvl_o        (intx_lvl),
        .mask_o       (intx_mask),
        .pend_o       (intx_pend)
    );

    // control register
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.en = reg_wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // read mux
    always_comb begin
        case (reg_addr_i)
            ADDR_W'(SEL_MISC_STAT): reg_rdata_o = misc_stat;
            ADDR_W'(SEL_MISC_EN):   reg_rdata_o = misc_mask;
            ADDR_W'(SEL_INTX_STAT): reg_rdata_o = {{PAD_W{1'b0}}, intx_lvl};
            ADDR_W'(SEL_INTX_EN):   reg_rdata_o = {{PAD_W{1'b0}}, intx_mask};
            ADDR_W'(SEL_CTRL):      reg_rdata_o = {{(DATA_W-1){1'b0}}, ctl_q.en};
            default:                reg_rdata_o = '0;
        endcase
    end

    assign misc_irq_o = ctl_q.en & misc_pend;
    assign intx_irq_o = ctl_q.en & intx_pend;

    // R8: a cleared global enable silences both lines
    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.en |-> (!misc_irq_o && !intx_irq_o));

    // R9: an enabled, unmasked pending event raises the event line
    assert_misc_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.en && ((misc_stat & misc_mask) != '0)) |-> misc_irq_o);

    // R10: the legacy line is low when no enabled level is active
    assert_intx_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((intx_lvl & intx_mask) == '0) |-> !intx_irq_o);

    // R11: unmapped words read zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i > ADDR_W'(SEL_CTRL)) |-> (reg_rdata_o == '0));

endmodule

// File: tb/test_evt_irq_agg.sv
module test_evt_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] misc_evt_i = '0;
    logic [3:0]  intx_lvl_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        misc_irq_o, intx_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] impl;

    always #2 clk = ~clk;

    evt_irq_agg i_evt_irq_agg (
        .clk(clk), .rst_n(rst_n), .misc_evt_i(misc_evt_i), .intx_lvl_i(intx_lvl_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .misc_irq_o(misc_irq_o), .intx_irq_o(intx_irq_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(logic [31:0] e);
        misc_evt_i = e;
        tick();
        misc_evt_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int pos[15] = '{0, 1, 4, 5, 6, 7, 16, 17, 18, 20, 22, 23, 24, 25, 26};
        impl = '0;
        foreach (pos[k]) impl[pos[k]] = 1'b1;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reset reg", d, 32'h0);
        end
        chk("R1 misc_irq", {31'h0, misc_irq_o}, 32'h0);
        chk("R1 intx_irq", {31'h0, intx_irq_o}, 32'h0);

        // R2/R3/R4: per-position sweep
        for (int b = 0; b < 32; b++) begin
            pulse(32'h1 << b);
            tick();
            rd(3'd0, d);
            chk("R2 R3 latch sticky", d, (32'h1 << b) & impl);
            wr(3'd0, ~(32'h1 << b));
            rd(3'd0, d);
            chk("R4 write zero keeps", d, (32'h1 << b) & impl);
            wr(3'd0, 32'h1 << b);
            rd(3'd0, d);
            chk("R4 write one clears", d, 32'h0);
        end

        // R4: partial clear of a multi-bit pattern
        pulse(32'hFFFF_FFFF);
        wr(3'd0, 32'h00F0_00F0);
        rd(3'd0, d);
        chk("R4 partial clear", d, impl & ~32'h00F0_00F0);
        wr(3'd0, '1);

        // R5: set wins over a same-cycle clear
        misc_evt_i = 32'h0100_0001;
        wr(3'd0, 32'h0100_0003);
        misc_evt_i = '0;
        rd(3'd0, d);
        chk("R5 set wins", d, 32'h0100_0001);
        wr(3'd0, '1);

        // R7/R3: mask readback
        wr(3'd1, '1);
        rd(3'd1, d);
        chk("R7 R3 misc mask readback", d, impl);
        wr(3'd3, '1);
        rd(3'd3, d);
        chk("R7 intx mask readback", d, 32'h0000_000F);

        // R8: control readback
        wr(3'd4, '1);
        rd(3'd4, d);
        chk("R8 ctrl readback", d, 32'h1);

        // R9/R8: event line per position
        for (int b = 0; b < 32; b++) begin
            wr(3'd0, '1);
            wr(3'd4, 32'h1);
            wr(3'd1, 32'h1 << b);
            pulse(32'h1 << b);
            chk("R9 line on match", {31'h0, misc_irq_o}, {31'h0, impl[b]});
            wr(3'd1, ~(32'h1 << b));
            chk("R9 line masked", {31'h0, misc_irq_o}, 32'h0);
            wr(3'd1, 32'h1 << b);
            wr(3'd4, 32'h0);
            chk("R8 misc gated", {31'h0, misc_irq_o}, 32'h0);
        end
        wr(3'd0, '1);

        // R6/R10/R8: legacy sweep
        for (int en = 0; en < 2; en++) begin
            wr(3'd4, 32'(en));
            for (int lv = 0; lv < 16; lv++) begin
                for (int mk = 0; mk < 16; mk++) begin
                    intx_lvl_i = 4'(lv);
                    wr(3'd3, 32'(mk));
                    rd(3'd2, d);
                    chk("R6 level status", d, 32'(lv));
                    chk("R10 R8 intx line", {31'h0, intx_irq_o},
                        {31'h0, (en == 1) && ((lv & mk) != 0)});
                end
            end
        end

        // R6: write to legacy status ignored
        intx_lvl_i = 4'h5;
        tick();
        wr(3'd2, '1);
        rd(3'd2, d);
        chk("R6 write ignored", d, 32'h5);

        // R11: unmapped words
        pulse(32'h0000_0003);
        wr(3'd1, 32'h0000_0002);
        wr(3'd3, 32'h0000_0004);
        wr(3'd4, 32'h1);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), '1);
            rd(3'(a), d);
            chk("R11 unmapped reads zero", d, 32'h0);
        end
        rd(3'd0, d); chk("R11 stat unchanged", d, 32'h3);
        rd(3'd1, d); chk("R11 mask unchanged", d, 32'h2);
        rd(3'd3, d); chk("R11 intx mask unchanged", d, 32'h4);
        rd(3'd4, d); chk("R11 ctrl unchanged", d, 32'h1);
        chk("R9 line with overlap", {31'h0, misc_irq_o}, 32'h1);
        chk("R10 line with lvl 5 mask 4", {31'h0, intx_irq_o}, 32'h1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule